// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block watches the accesses of two ports that share one word-addressed memory and keeps one interrupt flag per port, driven low when active. Two word addresses at the top of the address space act as mailboxes: the all-ones address belongs to the right port and the address one below it belongs to the left port. A port that writes into the other side's mailbox raises that side's interrupt. The owner drops its own interrupt by reading its own mailbox. The message data lives in the ordinary memory words and is not handled here.

Each port presents, once per clock, a select, a write strobe, a word address and the busy flag it receives from the arbiter. A port that is busy can neither raise the other side's interrupt nor clear its own. Flags change on the clock edge that samples the access, so an interrupt output moves one cycle after the access that causes it.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset both `l_irq_n` and `r_irq_n` are high (inactive).
- R2: The right mailbox is the all-ones address of width `ADDR_W`; the left mailbox is all-ones minus one; with the default `ADDR_W` of 12 these are 0xFFF and 0xFFE.
- R3: A left write (`l_sel`=1, `l_we`=1, `l_busy`=0) to the right mailbox drives `r_irq_n` low from the next clock edge.
- R4: A right write (`r_sel`=1, `r_we`=1, `r_busy`=0) to the left mailbox drives `l_irq_n` low from the next clock edge.
- R5: A read (`sel`=1, `we`=0, `busy`=0) by a port of its own mailbox returns that port's interrupt output to high on the next clock edge.
- R6: A read by a port of the other side's mailbox changes neither interrupt output.
- R7: While a port's busy input is high, its write to the other side's mailbox leaves the other side's interrupt output unchanged.
- R8: While a port's busy input is high, its read of its own mailbox leaves its own interrupt output unchanged.
- R9: When one interrupt is set and cleared in the same cycle, it ends up active (low).
- R10: Writes to a port's own mailbox, and accesses to any non-mailbox address, change neither interrupt output.
- R11: With no qualifying access, both interrupt outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_sel | input | 1 | Left port access this cycle |
| l_we | input | 1 | Left access is a write (1) or a read (0) |
| l_addr | input | ADDR_W | Left word address |
| l_busy | input | 1 | Arbiter busy to the left port |
| r_sel | input | 1 | Right port access this cycle |
| r_we | input | 1 | Right access is a write (1) or a read (0) |
| r_addr | input | ADDR_W | Right word address |
| r_busy | input | 1 | Arbiter busy to the right port |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Set and clear are each driven from both sides, and the same accesses are repeated with busy high, so a busy gate missing on either operation or on either side shows as a flag that moves when it should hold. Reads of the peer's mailbox, writes to a port's own mailbox and accesses to an address next to the mailboxes separate the correct address and direction decode from one that swaps the mailboxes or ignores the write strobe. A cycle where the left port writes the right mailbox while the right port reads it tells the set-wins ordering from clear-wins.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;

   typedef struct packed {
      logic raise_peer;
      logic clear_own;
   } mbx_req_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
   import mbx_pkg::*;
#(
   parameter int    ADDR_W = 12,
   parameter side_e SIDE   = SIDE_LEFT
) (
   input  logic              sel,
   input  logic              we,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   output mbx_req_t          req
);
   localparam logic [ADDR_W-1:0] BOX_HI = '1;
   localparam logic [ADDR_W-1:0] BOX_LO = BOX_HI - 1'b1;
   localparam logic [ADDR_W-1:0] OWN_BOX  = (SIDE == SIDE_RIGHT) ? BOX_HI : BOX_LO;
   localparam logic [ADDR_W-1:0] PEER_BOX = (SIDE == SIDE_RIGHT) ? BOX_LO : BOX_HI;

   logic granted;

   always_comb begin
      granted        = sel && !busy;
      req.raise_peer = granted && we  && (addr == PEER_BOX);
      req.clear_own  = granted && !we && (addr == OWN_BOX);
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_sel,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              l_busy,
   input  logic              r_sel,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              r_busy,
   output logic              l_irq_n,
   output logic              r_irq_n
);
   localparam int NSIDE = 2;

   if (ADDR_W < 2) begin : g_bad_width
      $error("mbx_irq_ctrl: ADDR_W must be at least 2");
   end

   logic              p_sel  [NSIDE];
   logic              p_we   [NSIDE];
   logic              p_busy [NSIDE];
   logic [ADDR_W-1:0] p_addr [NSIDE];
   mbx_req_t          p_req  [NSIDE];
   logic              p_flag [NSIDE];

   always_comb begin
      p_sel[0]  = l_sel;   p_sel[1]  = r_sel;
      p_we[0]   = l_we;    p_we[1]   = r_we;
      p_busy[0] = l_busy;  p_busy[1] = r_busy;
      p_addr[0] = l_addr;  p_addr[1] = r_addr;
   end

   for (genvar s = 0; s < NSIDE; s++) begin : g_side
      mbx_port_decode #(
         .ADDR_W (ADDR_W),
         .SIDE   (side_e'(s))
      ) u_dec (
         .sel  (p_sel[s]),
         .we   (p_we[s]),
         .busy (p_busy[s]),
         .addr (p_addr[s]),
         .req  (p_req[s])
      );

      mbx_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (p_req[NSIDE-1-s].raise_peer),
         .clr_i  (p_req[s].clear_own),
         .flag_o (p_flag[s])
      );
   end

   assign l_irq_n = ~p_flag[0];
   assign r_irq_n = ~p_flag[1];
endmodule

// File: rtl/mbx_irq_checker.sv
module mbx_irq_checker #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_sel,
   input logic              l_we,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_busy,
   input logic              r_sel,
   input logic              r_we,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_busy,
   input logic              l_irq_n,
   input logic              r_irq_n
);
   localparam logic [ADDR_W-1:0] HI = '1;
   localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

   logic set_r, set_l, clr_r, clr_l;
   assign set_r = l_sel && l_we  && !l_busy && (l_addr == HI);
   assign set_l = r_sel && r_we  && !r_busy && (r_addr == LO);
   assign clr_r = r_sel && !r_we && !r_busy && (r_addr == HI);
   assign clr_l = l_sel && !l_we && !l_busy && (l_addr == LO);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (l_irq_n && r_irq_n));
   assert_set_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_r |=> !r_irq_n);
   assert_set_left_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_l |=> !l_irq_n);
   assert_clear_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_r && !set_r) |=> r_irq_n);
   assert_clear_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_l && !set_l) |=> l_irq_n);
   assert_busy_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (r_irq_n && l_busy) |=> r_irq_n);
   assert_busy_no_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_irq_n && l_busy) |=> !l_irq_n);
   assert_hold_right_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_r && !clr_r) |=> $stable(r_irq_n));
   assert_hold_left_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_l && !clr_l) |=> $stable(l_irq_n));
endmodule

bind mbx_irq_ctrl mbx_irq_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_busy(l_busy),
   .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_busy(r_busy),
   .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/sim_mbx_irq_ctrl.sv
module sim_mbx_irq_ctrl;
   localparam int AW = 12;
   localparam logic [AW-1:0] BOX_R = 12'hFFF;
   localparam logic [AW-1:0] BOX_L = 12'hFFE;

   logic clk = 1'b0, rst_n = 1'b0;
   logic l_sel = 0, l_we = 0, l_busy = 0, r_sel = 0, r_we = 0, r_busy = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_irq_n, r_irq_n;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   mbx_irq_ctrl #(.ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .l_sel(l_sel), .l_we(l_we), .l_addr(l_addr), .l_busy(l_busy),
      .r_sel(r_sel), .r_we(r_we), .r_addr(r_addr), .r_busy(r_busy),
      .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
   );

   task automatic check(string req, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // one access cycle on each side; outputs sampled at the following negedge
   task automatic step(logic ls, logic lw, logic [AW-1:0] la, logic lb,
                       logic rs, logic rw, logic [AW-1:0] ra, logic rb);
      @(negedge clk);
      l_sel = ls; l_we = lw; l_addr = la; l_busy = lb;
      r_sel = rs; r_we = rw; r_addr = ra; r_busy = rb;
      @(negedge clk);
      l_sel = 0; l_we = 0; l_addr = '0; l_busy = 0;
      r_sel = 0; r_we = 0; r_addr = '0; r_busy = 0;
   endtask

   task automatic l_acc(logic we, logic [AW-1:0] a, logic b);
      step(1, we, a, b, 0, 0, '0, 0);
   endtask
   task automatic r_acc(logic we, logic [AW-1:0] a, logic b);
      step(0, 0, '0, 0, 1, we, a, b);
   endtask

   task automatic clear_both();
      l_acc(0, BOX_L, 0);
      r_acc(0, BOX_R, 0);
   endtask

   task automatic t_reset();
      check("R1 l_irq_n after reset", l_irq_n, 1'b1);
      check("R1 r_irq_n after reset", r_irq_n, 1'b1);
   endtask

   task automatic t_set_clear_right();
      l_acc(1, BOX_R, 0);
      check("R3 R2 left write 0xFFF sets r_irq", r_irq_n, 1'b0);
      check("R3 left irq untouched", l_irq_n, 1'b1);
      repeat (3) @(negedge clk);
      check("R11 r_irq holds", r_irq_n, 1'b0);
      r_acc(0, BOX_R, 0);
      check("R5 right read 0xFFF clears r_irq", r_irq_n, 1'b1);
   endtask

   task automatic t_set_clear_left();
      r_acc(1, BOX_L, 0);
      check("R4 R2 right write 0xFFE sets l_irq", l_irq_n, 1'b0);
      check("R4 right irq untouched", r_irq_n, 1'b1);
      l_acc(0, BOX_L, 0);
      check("R5 left read 0xFFE clears l_irq", l_irq_n, 1'b1);
   endtask

   task automatic t_peer_read();
      l_acc(1, BOX_R, 0);
      r_acc(1, BOX_L, 0);
      l_acc(0, BOX_R, 0);
      check("R6 left reads peer box, r_irq stays", r_irq_n, 1'b0);
      check("R6 left reads peer box, l_irq stays", l_irq_n, 1'b0);
      r_acc(0, BOX_L, 0);
      check("R6 right reads peer box, l_irq stays", l_irq_n, 1'b0);
      check("R6 right reads peer box, r_irq stays", r_irq_n, 1'b0);
      clear_both();
      check("R5 both cleared", l_irq_n & r_irq_n, 1'b1);
   endtask

   task automatic t_busy_set();
      l_acc(1, BOX_R, 1);
      check("R7 busy left write cannot set r_irq", r_irq_n, 1'b1);
      r_acc(1, BOX_L, 1);
      check("R7 busy right write cannot set l_irq", l_irq_n, 1'b1);
   endtask

   task automatic t_busy_clear();
      l_acc(1, BOX_R, 0);
      r_acc(1, BOX_L, 0);
      r_acc(0, BOX_R, 1);
      check("R8 busy right read cannot clear r_irq", r_irq_n, 1'b0);
      l_acc(0, BOX_L, 1);
      check("R8 busy left read cannot clear l_irq", l_irq_n, 1'b0);
      clear_both();
   endtask

   task automatic t_collision();
      step(1, 1, BOX_R, 0, 1, 0, BOX_R, 0);
      check("R9 set beats clear on r_irq", r_irq_n, 1'b0);
      step(1, 0, BOX_L, 0, 1, 1, BOX_L, 0);
      check("R9 set beats clear on l_irq", l_irq_n, 1'b0);
      clear_both();
   endtask

   task automatic t_other_addr();
      l_acc(1, BOX_L, 0);
      check("R10 left write own box no l_irq", l_irq_n, 1'b1);
      check("R10 left write own box no r_irq", r_irq_n, 1'b1);
      r_acc(1, BOX_R, 0);
      check("R10 right write own box no r_irq", r_irq_n, 1'b1);
      l_acc(1, 12'hFFD, 0);
      r_acc(1, 12'h7FF, 0);
      check("R10 non-box writes no r_irq", r_irq_n, 1'b1);
      check("R10 non-box writes no l_irq", l_irq_n, 1'b1);
      l_acc(1, BOX_R, 0);
      r_acc(0, 12'hFFD, 0);
      check("R10 non-box read keeps r_irq", r_irq_n, 1'b0);
      r_acc(0, BOX_R, 0);
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_clear_right();
      t_set_clear_left();
      t_peer_read();
      t_busy_set();
      t_busy_clear();
      t_collision();
      t_other_addr();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule